// File: doc/BRIEF.md
# Flash Program/Erase Busy Status Generator

This block produces the polled status byte that a parallel flash model returns while a program or erase operation is in flight, and it times erase completion. A command decoder, which is outside this block, issues single-cycle start pulses for program, sector erase and chip erase. The block holds the status byte, raises a busy flag while an erase runs, and pulses a completion strobe. A companion flag tells the decoder where to go next: the read array, or the shortened bypass command cycle.

Programming is treated as instantaneous. The status byte takes the inverted data bit 7 in its top bit and ones everywhere else, and completion is signalled on the next cycle. An erase clears the status byte and loads a down-counter; the chip-erase duration is a fixed multiple of the sector-erase duration, both counted in clock cycles. Every status read during an erase flips bit 6, so a polling host sees it alternate. At expiry, bit 7 inverts, which signals completion to a host that polls data.

Top module: `flash_busy_status`

## Requirements
- R1: After reset, status_o is 0x00 and busy_o and done_o are low.
- R2: A program start while idle sets status_o on the next cycle to {~data bit 7, 7'b111_1111}, keeps busy_o low, and pulses done_o high for exactly one cycle.
- R3: A sector-erase start while idle gives status_o = 0x00 and busy_o high on the next cycle, and busy_o then stays high for exactly SECT_CYCLES cycles.
- R4: A chip-erase start while idle behaves like R3, but busy_o stays high for exactly SECT_CYCLES*CHIP_RATIO cycles (default ratio 10).
- R5: In the first cycle after busy_o falls, done_o is high for one cycle and status bit 7 has been inverted.
- R6: A status read while busy_o is high leaves status_o unchanged in the read cycle and inverts bit 6 in the next cycle.
- R7: A status read while busy_o is low changes nothing in status_o.
- R8: Start pulses of any kind that arrive while busy_o is high are ignored. Neither the status byte nor the remaining erase duration changes.
- R9: When several starts arrive in the same idle cycle, chip erase wins over sector erase, and sector erase wins over program.
- R10: done_bypass_o is high together with done_o exactly when bypass_i was high in the cycle that ended the operation; it is low whenever done_o is low.
- R11: A status read in the last busy cycle inverts both bit 6 and bit 7 at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_start_i | input | 1 | Program start pulse from the decoder |
| prog_data_i | input | 8 | Byte being programmed |
| sect_erase_start_i | input | 1 | Sector-erase start pulse |
| chip_erase_start_i | input | 1 | Chip-erase start pulse |
| bypass_i | input | 1 | Decoder is in unlock-bypass mode |
| status_rd_i | input | 1 | Status read strobe |
| status_o | output | 8 | Polled status byte |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | One-cycle completion pulse |
| done_bypass_o | output | 1 | With done_o: return to the bypass command cycle rather than read mode |

## Verification
Two status-byte updates can coincide: the read-driven toggle of bit 6 and the timer-driven inversion of bit 7 at expiry. The bench provokes this by asserting the read strobe in precisely the last busy cycle of both erase lengths. It judges the result by requiring both bits to have flipped on the cycle done_o rises. It also fires starts of every kind in the middle of an erase, so that the ignore path is tested against a running timer.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef logic [7:0] status_t;
  localparam logic [6:0] PROG_LOW_BITS = 7'h7F;
  localparam int TOGGLE_BIT = 6;
  localparam int POLL_BIT   = 7;
endpackage

// File: rtl/fbs_timer.sv
module fbs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             run_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i - CNT_W'(1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign run_o    = run_q;
  assign expire_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/fbs_status.sv
module fbs_status
  import fbs_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    erase_clr_i,
  input  logic    prog_set_i,
  input  logic    prog_bit7_i,
  input  logic    rd_toggle_i,
  input  logic    expire_i,
  output status_t status_o
);
  status_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (erase_clr_i) begin
      st_d = '0;
    end else if (prog_set_i) begin
      st_d = {~prog_bit7_i, PROG_LOW_BITS};
    end else begin
      st_d[POLL_BIT]   = st_q[POLL_BIT] ^ expire_i;
      st_d[TOGGLE_BIT] = st_q[TOGGLE_BIT] ^ rd_toggle_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign status_o = st_q;
endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
  import fbs_pkg::*;
#(
  parameter int SECT_CYCLES = 20,
  parameter int CHIP_RATIO  = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       prog_start_i,
  input  logic [7:0] prog_data_i,
  input  logic       sect_erase_start_i,
  input  logic       chip_erase_start_i,
  input  logic       bypass_i,
  input  logic       status_rd_i,
  output logic [7:0] status_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       done_bypass_o
);
  localparam int CHIP_CYCLES = SECT_CYCLES * CHIP_RATIO;
  localparam int CNT_W       = $clog2(CHIP_CYCLES + 1);

  logic             run, expire, idle;
  logic             erase_go, prog_go;
  logic [CNT_W-1:0] load_val;
  logic             done_q, byp_q;
  status_t          st;

  assign idle     = !run;
  assign erase_go = idle && (chip_erase_start_i || sect_erase_start_i);
  assign prog_go  = idle && prog_start_i && !chip_erase_start_i && !sect_erase_start_i;
  assign load_val = chip_erase_start_i ? CNT_W'(CHIP_CYCLES) : CNT_W'(SECT_CYCLES);

  fbs_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (erase_go),
    .load_val_i (load_val),
    .run_o      (run),
    .expire_o   (expire)
  );

  fbs_status i_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .erase_clr_i (erase_go),
    .prog_set_i  (prog_go),
    .prog_bit7_i (prog_data_i[7]),
    .rd_toggle_i (status_rd_i && run),
    .expire_i    (expire),
    .status_o    (st)
  );

  // completion strobe, destination latched at the finishing edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      byp_q  <= 1'b0;
    end else begin
      done_q <= expire || prog_go;
      if (expire || prog_go) byp_q <= bypass_i;
    end
  end

  assign status_o      = st;
  assign busy_o        = run;
  assign done_o        = done_q;
  assign done_bypass_o = done_q && byp_q;
endmodule

// File: rtl/fbs_checker.sv
module fbs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       prog_start_i,
  input logic [7:0] prog_data_i,
  input logic       sect_erase_start_i,
  input logic       chip_erase_start_i,
  input logic       status_rd_i,
  input logic [7:0] status_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       done_bypass_o
);
  p_prog_status_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && prog_start_i && !sect_erase_start_i && !chip_erase_start_i)
    |=> (status_o == {~$past(prog_data_i[7]), 7'h7F}) && done_o && !busy_o);

  p_erase_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (sect_erase_start_i || chip_erase_start_i))
    |=> (status_o == 8'h00) && busy_o);

  p_fall_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_read_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && status_rd_i) |=> (status_o[6] != $past(status_o[6])));

  p_idle_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && status_rd_i && !prog_start_i && !sect_erase_start_i && !chip_erase_start_i)
    |=> $stable(status_o));

  p_ignore_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !status_rd_i) |=> (status_o[6:0] == $past(status_o[6:0])));

  p_bypass_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_bypass_o |-> done_o);

  p_done_busy_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, busy_o}));
endmodule

bind flash_busy_status fbs_checker i_fbs_checker (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .prog_start_i       (prog_start_i),
  .prog_data_i        (prog_data_i),
  .sect_erase_start_i (sect_erase_start_i),
  .chip_erase_start_i (chip_erase_start_i),
  .status_rd_i        (status_rd_i),
  .status_o           (status_o),
  .busy_o             (busy_o),
  .done_o             (done_o),
  .done_bypass_o      (done_bypass_o)
);

// File: tb/test_flash_busy_status.sv
module test_flash_busy_status;
  localparam int SECT  = 8;
  localparam int RATIO = 10;
  localparam int CHIP  = SECT * RATIO;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       prog_start_i = 1'b0;
  logic [7:0] prog_data_i = '0;
  logic       sect_erase_start_i = 1'b0;
  logic       chip_erase_start_i = 1'b0;
  logic       bypass_i = 1'b0;
  logic       status_rd_i = 1'b0;
  logic [7:0] status_o;
  logic       busy_o, done_o, done_bypass_o;

  int total = 0;
  int bad   = 0;
  logic [7:0] st_exp;

  always #5 clk_i = ~clk_i;

  flash_busy_status #(.SECT_CYCLES(SECT), .CHIP_RATIO(RATIO)) i_flash_busy_status (
    .clk_i, .rst_ni, .prog_start_i, .prog_data_i, .sect_erase_start_i,
    .chip_erase_start_i, .bypass_i, .status_rd_i, .status_o, .busy_o,
    .done_o, .done_bypass_o
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h @%0t", req, act, exp, $time);
    end
  endtask

  // program start; sampled one edge later
  task automatic do_prog(input logic [7:0] d, input logic byp);
    @(negedge clk_i);
    prog_start_i = 1'b1; prog_data_i = d; bypass_i = byp;
    @(negedge clk_i);
    prog_start_i = 1'b0;
    st_exp = {~d[7], 7'h7F};
    chk("R2 status", status_o, st_exp);
    chk("R2 busy", busy_o, 0);
    chk("R2 done", done_o, 1);
    chk("R10 prog bypass", done_bypass_o, byp);
    @(negedge clk_i);
    chk("R2 done one cycle", done_o, 0);
    chk("R10 low without done", done_bypass_o, 0);
  endtask

  // erase: nrd reads from cycle 0, optional read in last cycle, optional starts mid-run
  task automatic do_erase(input bit chip, input bit also_sect, input logic byp,
                          input int nrd, input bit rd_last, input bit poke);
    int dur, par;
    dur = chip ? CHIP : SECT;
    @(negedge clk_i);
    chip_erase_start_i = chip; sect_erase_start_i = !chip || also_sect;
    prog_start_i = also_sect; prog_data_i = 8'h00; bypass_i = byp;
    @(negedge clk_i);
    chip_erase_start_i = 1'b0; sect_erase_start_i = 1'b0; prog_start_i = 1'b0;
    chk("R3 cleared", status_o, 8'h00);
    par = 0;
    for (int i = 0; i < dur; i++) begin
      chk(chip ? "R4 busy" : "R3 busy", busy_o, 1);
      chk("R6 bit6 parity", status_o, {1'b0, par[0], 6'b0});
      chk("R5 no early done", done_o, 0);
      status_rd_i = (i < nrd) || (rd_last && i == dur - 1);
      if (status_rd_i) par++;
      if (poke && i == 2) begin
        prog_start_i = 1'b1; sect_erase_start_i = 1'b1; chip_erase_start_i = 1'b1;
      end
      @(negedge clk_i);
      status_rd_i = 1'b0;
      prog_start_i = 1'b0; sect_erase_start_i = 1'b0; chip_erase_start_i = 1'b0;
      if (poke && i == 2) chk("R8 start ignored", status_o, {1'b0, par[0], 6'b0});
    end
    chk(chip ? "R4 busy fell" : "R3 busy fell", busy_o, 0);
    chk("R5 done", done_o, 1);
    chk(rd_last ? "R11 both bits" : "R5 bit7", status_o, {1'b1, par[0], 6'b0});
    chk("R10 erase bypass", done_bypass_o, byp);
    @(negedge clk_i);
    chk("R5 done one cycle", done_o, 0);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk("R1 status", status_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 status after release", status_o, 0);

    for (int d = 0; d < 256; d++) do_prog(8'(d), d[0]);

    // R7: idle reads after program
    @(negedge clk_i);
    status_rd_i = 1'b1;
    repeat (3) @(negedge clk_i);
    status_rd_i = 1'b0;
    chk("R7 idle read", status_o, {~8'hFF, 7'h7F} & 8'hFF);

    for (int n = 0; n <= SECT; n++) do_erase(1'b0, 1'b0, n[0], n, 1'b0, 1'b0);
    do_erase(1'b0, 1'b0, 1'b1, 0, 1'b1, 1'b0);   // R11 sector
    do_erase(1'b0, 1'b0, 1'b0, 3, 1'b1, 1'b1);   // R8 + R11
    do_erase(1'b1, 1'b0, 1'b1, 5, 1'b0, 1'b1);   // R4 + R8
    do_erase(1'b1, 1'b0, 1'b0, 0, 1'b1, 1'b0);   // R4 + R11
    do_erase(1'b1, 1'b1, 1'b0, 2, 1'b0, 1'b0);   // R9 chip beats all
    do_erase(1'b0, 1'b1, 1'b1, 1, 1'b0, 1'b0);   // R9 sector beats program

    // R7: idle read after erase completion
    st_exp = status_o;
    status_rd_i = 1'b1;
    repeat (4) @(negedge clk_i);
    status_rd_i = 1'b0;
    chk("R7 idle read after erase", status_o, st_exp);
    chk("R7 busy", busy_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule